// File: doc/BRIEF.md
# Register Access Guard Sequencer

This block sits between a single-request register master and a register slave that can hang when its internal registers are touched without preparation. For every accepted request it can surround the real read or write with extra read accesses to fixed "preparation" and "settling" offsets in the same register window. The slave ignores the data these extra reads return; they exist only to put it in a safe condition.

Which extra reads are issued depends on the request's offset from a base-address input. One extra read always comes before the real access. One optional read and one final read come after it. The guarding only happens when a revision input matches the affected silicon revision and the offset lies below a limit. Any other request is forwarded as one plain access. Both sides use a valid/ready request and a one-cycle response strobe, with at most one transaction in flight.

Top module: `reg_guard_seq`

## Requirements
- R1: After reset the block is idle: `up_ready_o` is 1, `dn_valid_o` is 0 and `up_rvalid_o` is 0.
- R2: When `rev_i` differs from the guarded revision value (default 1), exactly one downstream access is made. It carries the request's address, write flag and write data.
- R3: When the offset (`up_addr_i - base_i`) is at or above the guard limit (default 0x45000), exactly one plain downstream access is made. An offset of 0x44FFF is still guarded.
- R4: In a guarded access with offset 0x0 or 0x80, the first downstream access is a read at base + 0xC0.
- R5: In a guarded access with offset 0x148 or 0x200, the first downstream access is a read at base + 0x28.
- R6: In a guarded access with any other offset, the first downstream access is a read at base + 0x158.
- R7: In a guarded access with offset 0x100, a read at base + 0x38 follows the real access. No other offset produces this read.
- R8: Every guarded sequence ends with a read at base + 0xB050, after the real access and after any 0x38 read.
- R9: All extra accesses are reads (`dn_we_o` = 0). A new downstream request is raised only after the previous one's `dn_rvalid_i` has arrived. `dn_valid_o` and its address stay stable until `dn_ready_i`.
- R10: The upstream response is one `up_rvalid_o` pulse, given only after the last downstream response. For reads it carries the real access's data, never data from an extra read. Writes also get a pulse.
- R11: `up_ready_o` drops after a request is accepted and stays low until the response pulse has been given.
- R12: Every downstream address is the base plus the offset, computed modulo 2^AW. The base is captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rev_i | input | REV_W | Silicon revision code of the slave |
| base_i | input | AW | Base address of the register window |
| up_valid_i | input | 1 | Upstream request valid |
| up_ready_o | output | 1 | Upstream request accepted when high with valid |
| up_addr_i | input | AW | Upstream request address |
| up_we_i | input | 1 | Upstream write flag |
| up_wdata_i | input | DW | Upstream write data |
| up_rvalid_o | output | 1 | One-cycle upstream completion strobe |
| up_rdata_o | output | DW | Read data of the real access |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request accepted |
| dn_addr_o | output | AW | Downstream address |
| dn_we_o | output | 1 | Downstream write flag |
| dn_wdata_o | output | DW | Downstream write data |
| dn_rvalid_i | input | 1 | Downstream completion strobe |
| dn_rdata_i | input | DW | Downstream read data |

## Verification
The bench sends reads and writes at each offset that selects a different preparation read: 0x0, 0x80, 0x148, 0x200, the 0x100 trigger, and an ordinary offset. This separates the three preparation targets and shows that the 0x38 read belongs to 0x100 alone. Offsets of 0x44FFF and 0x45000, and a revision that does not match, distinguish guarded requests from plain pass-through. A base near the top of the address space checks the modular address arithmetic. The slave model answers after random delays and gives each address its own data, so a returned dummy value or an early response would be caught. A write followed by a read of the same offset shows that the real data path is kept.

// File: rtl/reg_guard_pkg.sv
// Package: shared step/state types and the fixed guard offsets.
// Assumes offsets fit in 32 bits; they are widened to AW at use.
package reg_guard_pkg;

    typedef enum logic [1:0] {
        STEP_PRE  = 2'd0,
        STEP_REAL = 2'd1,
        STEP_POST = 2'd2,
        STEP_LAST = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

    // Offsets that select the preparation read
    localparam logic [31:0] OFF_GRP_A0 = 32'h0;
    localparam logic [31:0] OFF_GRP_A1 = 32'h80;
    localparam logic [31:0] OFF_GRP_B0 = 32'h148;
    localparam logic [31:0] OFF_GRP_B1 = 32'h200;
    // Preparation read targets
    localparam logic [31:0] PREP_A     = 32'hC0;
    localparam logic [31:0] PREP_B     = 32'h28;
    localparam logic [31:0] PREP_OTHER = 32'h158;
    // Offset that needs an extra settling read, and its target
    localparam logic [31:0] OFF_TRIG   = 32'h100;
    localparam logic [31:0] SETTLE_X   = 32'h38;
    // Settling read that closes every guarded sequence
    localparam logic [31:0] SETTLE_END = 32'hB050;

endpackage

// File: rtl/reg_guard_plan.sv
// Module: reg_guard_plan
// Decides, from revision, base and requested address, whether a request is
// guarded and which extra reads it needs. Purely combinational.
// Assumes AW >= 32 so the package offsets widen without loss.
module reg_guard_plan
    import reg_guard_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          REV_W       = 4,
    parameter int unsigned REV_GUARDED = 1,
    parameter int unsigned GUARD_LIMIT = 32'h45000
) (
    input  logic [REV_W-1:0] rev_i,
    input  logic [AW-1:0]    base_i,
    input  logic [AW-1:0]    addr_i,
    output logic [AW-1:0]    off_o,
    output logic             guard_o,
    output logic [AW-1:0]    prep_o,
    output logic             extra_o
);

    localparam logic [REV_W-1:0] REV_MATCH = REV_W'(REV_GUARDED);
    localparam logic [AW-1:0]    LIMIT     = AW'(GUARD_LIMIT);

    // Offset of the request inside the register window (modulo 2^AW)
    always_comb off_o = addr_i - base_i;

    // Guarding is active only for the affected revision and low offsets
    always_comb guard_o = (rev_i == REV_MATCH) && (off_o < LIMIT);

    // Choose the preparation read target from the offset group
    always_comb begin
        if (off_o == AW'(OFF_GRP_A0) || off_o == AW'(OFF_GRP_A1))
            prep_o = AW'(PREP_A);
        else if (off_o == AW'(OFF_GRP_B0) || off_o == AW'(OFF_GRP_B1))
            prep_o = AW'(PREP_B);
        else
            prep_o = AW'(PREP_OTHER);
    end

    // Only the trigger offset needs the additional settling read
    always_comb extra_o = (off_o == AW'(OFF_TRIG));

endmodule

// File: rtl/reg_guard_steps.sv
// Module: reg_guard_steps
// Step ordering of one sequence: preparation, real, optional settle, final.
// Combinational; assumes the caller holds the current step in a register.
module reg_guard_steps
    import reg_guard_pkg::*;
(
    input  step_e cur_i,
    input  logic  guard_i,
    input  logic  extra_i,
    output step_e first_o,
    output step_e next_o,
    output logic  final_o
);

    // A guarded sequence opens with the preparation read
    always_comb first_o = guard_i ? STEP_PRE : STEP_REAL;

    // The current step is the last one of this sequence
    always_comb final_o = guard_i ? (cur_i == STEP_LAST) : (cur_i == STEP_REAL);

    // Successor of the current step
    always_comb begin
        unique case (cur_i)
            STEP_PRE:  next_o = STEP_REAL;
            STEP_REAL: next_o = extra_i ? STEP_POST : STEP_LAST;
            STEP_POST: next_o = STEP_LAST;
            default:   next_o = STEP_LAST;
        endcase
    end

endmodule

// File: rtl/reg_guard_fsm.sv
// Module: reg_guard_fsm
// Captures one upstream request, walks its steps on the downstream bus one
// at a time, and returns a single response. Assumes one downstream response
// per accepted downstream request, arriving at least one cycle later.
module reg_guard_fsm
    import reg_guard_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic          up_valid_i,
    output logic          up_ready_o,
    input  logic          up_we_i,
    input  logic [DW-1:0] up_wdata_i,
    output logic          up_rvalid_o,
    output logic [DW-1:0] up_rdata_o,
    input  logic [AW-1:0] plan_off_i,
    input  logic          plan_guard_i,
    input  logic [AW-1:0] plan_prep_i,
    input  logic          plan_extra_i,
    output step_e         step_o,
    output logic          guard_o,
    output logic          extra_o,
    input  step_e         first_i,
    input  step_e         next_i,
    input  logic          final_i,
    output logic          dn_valid_o,
    input  logic          dn_ready_i,
    output logic [AW-1:0] dn_addr_o,
    output logic          dn_we_o,
    output logic [DW-1:0] dn_wdata_o,
    input  logic          dn_rvalid_i,
    input  logic [DW-1:0] dn_rdata_i
);

    state_e        state_q;
    step_e         step_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] off_q;
    logic [AW-1:0] prep_q;
    logic          guard_q;
    logic          extra_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic [AW-1:0] step_off;

    // Sequence state: idle, request on bus, awaiting response, answering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_REAL;
        end else begin
            unique case (state_q)
                ST_IDLE: if (up_valid_i) begin
                    state_q <= ST_ISSUE;
                    step_q  <= first_i;
                end
                ST_ISSUE: if (dn_ready_i) state_q <= ST_WAIT;
                ST_WAIT: if (dn_rvalid_i) begin
                    if (final_i) state_q <= ST_RESP;
                    else begin
                        state_q <= ST_ISSUE;
                        step_q  <= next_i;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture at acceptance (base included, so later changes are ignored)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            off_q   <= '0;
            prep_q  <= '0;
            guard_q <= 1'b0;
            extra_q <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && up_valid_i) begin
            base_q  <= base_i;
            off_q   <= plan_off_i;
            prep_q  <= plan_prep_i;
            guard_q <= plan_guard_i;
            extra_q <= plan_extra_i;
            we_q    <= up_we_i;
            wdata_q <= up_wdata_i;
        end
    end

    // Keep only the real access's response data
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (state_q == ST_WAIT && dn_rvalid_i && step_q == STEP_REAL)
            rdata_q <= dn_rdata_i;
    end

    // Offset used by the current step
    always_comb begin
        unique case (step_q)
            STEP_PRE:  step_off = prep_q;
            STEP_REAL: step_off = off_q;
            STEP_POST: step_off = AW'(SETTLE_X);
            default:   step_off = AW'(SETTLE_END);
        endcase
    end

    // Port drive
    always_comb begin
        up_ready_o  = (state_q == ST_IDLE);
        up_rvalid_o = (state_q == ST_RESP);
        up_rdata_o  = rdata_q;
        dn_valid_o  = (state_q == ST_ISSUE);
        dn_addr_o   = base_q + step_off;
        dn_we_o     = (step_q == STEP_REAL) && we_q;
        dn_wdata_o  = wdata_q;
        step_o      = step_q;
        guard_o     = guard_q;
        extra_o     = extra_q;
    end

    // R9: an offered downstream request holds until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(dn_addr_o));

    // R10: the upstream response directly follows a downstream completion
    p_resp_after_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid_o |-> $past(dn_rvalid_i));

    // R11: accepting a request closes the upstream side
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid_i && up_ready_o |=> !up_ready_o);

    // R8: a guarded response comes right after the closing settle read
    p_last_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid_o && guard_q |-> $past(dn_addr_o) == base_q + AW'(SETTLE_END));

    // R3: an unguarded response comes straight after the real access
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid_o && !guard_q |-> $past(step_q) == STEP_REAL);

endmodule

// File: rtl/reg_guard_seq.sv
// Module: reg_guard_seq (top)
// Wraps each register access in the preparation/settle reads a lockup-prone
// slave needs. Assumes single-outstanding buses on both sides.
module reg_guard_seq
    import reg_guard_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          DW          = 32,
    parameter int          REV_W       = 4,
    parameter int unsigned REV_GUARDED = 1,
    parameter int unsigned GUARD_LIMIT = 32'h45000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REV_W-1:0] rev_i,
    input  logic [AW-1:0]    base_i,
    input  logic             up_valid_i,
    output logic             up_ready_o,
    input  logic [AW-1:0]    up_addr_i,
    input  logic             up_we_i,
    input  logic [DW-1:0]    up_wdata_i,
    output logic             up_rvalid_o,
    output logic [DW-1:0]    up_rdata_o,
    output logic             dn_valid_o,
    input  logic             dn_ready_i,
    output logic [AW-1:0]    dn_addr_o,
    output logic             dn_we_o,
    output logic [DW-1:0]    dn_wdata_o,
    input  logic             dn_rvalid_i,
    input  logic [DW-1:0]    dn_rdata_i
);

    logic [AW-1:0] plan_off;
    logic          plan_guard;
    logic [AW-1:0] plan_prep;
    logic          plan_extra;
    step_e         cur_step;
    logic          cur_guard;
    logic          cur_extra;
    step_e         first_step;
    step_e         next_step;
    logic          final_step;

    reg_guard_plan #(
        .AW(AW), .REV_W(REV_W), .REV_GUARDED(REV_GUARDED), .GUARD_LIMIT(GUARD_LIMIT)
    ) u_plan (
        .rev_i   (rev_i),
        .base_i  (base_i),
        .addr_i  (up_addr_i),
        .off_o   (plan_off),
        .guard_o (plan_guard),
        .prep_o  (plan_prep),
        .extra_o (plan_extra)
    );

    // The first step is chosen from the incoming plan, later ones from the latched one
    reg_guard_steps u_first (
        .cur_i   (STEP_PRE),
        .guard_i (plan_guard),
        .extra_i (plan_extra),
        .first_o (first_step),
        .next_o  (),
        .final_o ()
    );

    reg_guard_steps u_steps (
        .cur_i   (cur_step),
        .guard_i (cur_guard),
        .extra_i (cur_extra),
        .first_o (),
        .next_o  (next_step),
        .final_o (final_step)
    );

    reg_guard_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_i       (base_i),
        .up_valid_i   (up_valid_i),
        .up_ready_o   (up_ready_o),
        .up_we_i      (up_we_i),
        .up_wdata_i   (up_wdata_i),
        .up_rvalid_o  (up_rvalid_o),
        .up_rdata_o   (up_rdata_o),
        .plan_off_i   (plan_off),
        .plan_guard_i (plan_guard),
        .plan_prep_i  (plan_prep),
        .plan_extra_i (plan_extra),
        .step_o       (cur_step),
        .guard_o      (cur_guard),
        .extra_o      (cur_extra),
        .first_i      (first_step),
        .next_i       (next_step),
        .final_i      (final_step),
        .dn_valid_o   (dn_valid_o),
        .dn_ready_i   (dn_ready_i),
        .dn_addr_o    (dn_addr_o),
        .dn_we_o      (dn_we_o),
        .dn_wdata_o   (dn_wdata_o),
        .dn_rvalid_i  (dn_rvalid_i),
        .dn_rdata_i   (dn_rdata_i)
    );

    // R9: extra (non-real) downstream accesses never write
    p_extra_is_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid_o && cur_step != STEP_REAL |-> !dn_we_o);

endmodule

// File: tb/reg_guard_seq_tb_top.sv
// Bench: behavioural slave with random latency, request-level reference
// model built from the requirements, per-clock protocol monitors.
module reg_guard_seq_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [3:0] REV_A     = 4'd1;
    localparam logic [3:0] REV_OTHER = 4'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rev_i = REV_A;
    logic [AW-1:0] base_i = '0;
    logic          up_valid_i = 1'b0;
    logic          up_ready_o;
    logic [AW-1:0] up_addr_i = '0;
    logic          up_we_i = 1'b0;
    logic [DW-1:0] up_wdata_i = '0;
    logic          up_rvalid_o;
    logic [DW-1:0] up_rdata_o;
    logic          dn_valid_o;
    logic          dn_ready_i = 1'b0;
    logic [AW-1:0] dn_addr_o;
    logic          dn_we_o;
    logic [DW-1:0] dn_wdata_o;
    logic          dn_rvalid_i = 1'b0;
    logic [DW-1:0] dn_rdata_i = '0;

    always #2 clk = ~clk;

    reg_guard_seq dut_i (
        .clk(clk), .rst_n(rst_n), .rev_i(rev_i), .base_i(base_i),
        .up_valid_i(up_valid_i), .up_ready_o(up_ready_o), .up_addr_i(up_addr_i),
        .up_we_i(up_we_i), .up_wdata_i(up_wdata_i), .up_rvalid_o(up_rvalid_o),
        .up_rdata_o(up_rdata_o), .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i),
        .dn_addr_o(dn_addr_o), .dn_we_o(dn_we_o), .dn_wdata_o(dn_wdata_o),
        .dn_rvalid_i(dn_rvalid_i), .dn_rdata_i(dn_rdata_i)
    );

    int checks = 0;
    int fails  = 0;
    int rand_ready = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Slave model: memory plus per-address default data
    logic [DW-1:0] mem [logic [AW-1:0]];
    function automatic logic [DW-1:0] rdval(input logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0], ~a[15:0]};
    endfunction

    logic [AW-1:0] lg_addr[$];
    bit            lg_we[$];
    logic [DW-1:0] lg_wd[$];

    bit            seen = 0;
    bit            outstanding = 0;
    int            lat = 0;
    logic [AW-1:0] acc_a;
    bit            acc_we;
    logic [DW-1:0] acc_wd;
    logic [DW-1:0] resp_d;

    // Slave: accepts, logs, answers after 1..3 cycles; monitors R9 each cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            dn_ready_i = 0; dn_rvalid_i = 0; outstanding = 0; seen = 0;
        end else begin
            if (dn_rvalid_i) dn_rvalid_i = 0;
            if (seen) begin
                lg_addr.push_back(acc_a); lg_we.push_back(acc_we); lg_wd.push_back(acc_wd);
                resp_d = rdval(acc_a);
                if (acc_we) mem[acc_a] = acc_wd;
                outstanding = 1; lat = 1 + int'($urandom % 3); seen = 0;
            end else if (outstanding) begin
                lat--;
                if (lat == 0) begin
                    dn_rvalid_i = 1; dn_rdata_i = resp_d; outstanding = 0;
                end
            end
            if (dn_valid_o && (outstanding || dn_rvalid_i))
                check(0, "R9", "request raised before completion", 1, 0);
            dn_ready_i = !outstanding && !dn_rvalid_i && (rand_ready == 0 || ($urandom % 2) == 1);
            seen = dn_valid_o && dn_ready_i;
            acc_a = dn_addr_o; acc_we = dn_we_o; acc_wd = dn_wdata_o;
        end
    end

    // One request through the block, compared against the reference list
    task automatic do_req(input logic [3:0] rev, input logic [AW-1:0] base,
                          input logic [AW-1:0] off, input bit we,
                          input logic [DW-1:0] wd, input string req);
        logic [AW-1:0] ea[$];
        bit            ew[$];
        logic [DW-1:0] exp_rd;
        int            wait_cnt;
        bit            guarded;
        guarded = (rev == REV_A) && (off < 32'h45000);
        if (guarded) begin
            if (off == 32'h0 || off == 32'h80)        ea.push_back(base + 32'hC0);
            else if (off == 32'h148 || off == 32'h200) ea.push_back(base + 32'h28);
            else                                       ea.push_back(base + 32'h158);
            ew.push_back(0);
        end
        ea.push_back(base + off); ew.push_back(we);
        if (guarded) begin
            if (off == 32'h100) begin ea.push_back(base + 32'h38); ew.push_back(0); end
            ea.push_back(base + 32'hB050); ew.push_back(0);
        end
        exp_rd = rdval(base + off);
        lg_addr.delete(); lg_we.delete(); lg_wd.delete();

        @(negedge clk);
        rev_i = rev; base_i = base; up_addr_i = base + off;
        up_we_i = we; up_wdata_i = wd; up_valid_i = 1;
        check(up_ready_o == 1, "R11", "ready while idle", up_ready_o, 1);
        @(negedge clk);
        up_valid_i = 0;
        base_i = ~base;  // later base changes must not matter (R12)
        wait_cnt = 0;
        while (!up_rvalid_o && wait_cnt < 100) begin
            if (up_ready_o) check(0, "R11", "ready during sequence", 1, 0);
            @(negedge clk);
            wait_cnt++;
        end
        check(up_rvalid_o == 1, req, "response seen", up_rvalid_o, 1);
        check(!outstanding && !seen, "R10", "response before last completion", outstanding, 0);
        check(lg_addr.size() == ea.size(), req, "access count", lg_addr.size(), ea.size());
        for (int i = 0; i < ea.size() && i < lg_addr.size(); i++) begin
            check(lg_addr[i] == ea[i], req, $sformatf("address of access %0d", i), lg_addr[i], ea[i]);
            check(lg_we[i] == ew[i], "R9", $sformatf("write flag of access %0d", i), lg_we[i], ew[i]);
            if (ew[i]) check(lg_wd[i] == wd, "R2", "write data", lg_wd[i], wd);
        end
        if (!we) check(up_rdata_o == exp_rd, "R10", "returned read data", up_rdata_o, exp_rd);
        @(negedge clk);
        check(up_rvalid_o == 0, "R10", "single response pulse", up_rvalid_o, 0);
    endtask

    bit done = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] offs [9];
        offs = '{32'h0, 32'h80, 32'h148, 32'h200, 32'h100, 32'h44FFF,
                 32'h45000, 32'h1234, 32'h8000000};
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle after reset
        check(up_ready_o == 1, "R1", "up_ready after reset", up_ready_o, 1);
        check(dn_valid_o == 0, "R1", "dn_valid after reset", dn_valid_o, 0);
        check(up_rvalid_o == 0, "R1", "up_rvalid after reset", up_rvalid_o, 0);

        do_req(REV_A, 32'h1000_0000, 32'h0,    0, 0, "R4");
        do_req(REV_A, 32'h1000_0000, 32'h80,   1, 32'hCAFE_0080, "R4");
        do_req(REV_A, 32'h1000_0000, 32'h148,  0, 0, "R5");
        do_req(REV_A, 32'h1000_0000, 32'h200,  1, 32'h0000_0200, "R5");
        do_req(REV_A, 32'h1000_0000, 32'h1234, 0, 0, "R6");
        do_req(REV_A, 32'h1000_0000, 32'h100,  0, 0, "R7");
        do_req(REV_A, 32'h1000_0000, 32'h104,  0, 0, "R7");
        do_req(REV_A, 32'h1000_0000, 32'h100,  1, 32'h1234_5678, "R8");
        do_req(REV_A, 32'h1000_0000, 32'h100,  0, 0, "R10");
        do_req(REV_A, 32'h1000_0000, 32'h44FFF, 0, 0, "R3");
        do_req(REV_A, 32'h1000_0000, 32'h45000, 0, 0, "R3");
        do_req(REV_A, 32'h1000_0000, 32'h45000, 1, 32'hAAAA_5555, "R3");
        do_req(REV_OTHER, 32'h1000_0000, 32'h0,   0, 0, "R2");
        do_req(REV_OTHER, 32'h1000_0000, 32'h100, 1, 32'h5555_AAAA, "R2");
        do_req(REV_A, 32'hFFFF_F000, 32'h100,  0, 0, "R12");
        do_req(REV_A, 32'hFFFF_0000, 32'h200,  0, 0, "R12");

        rand_ready = 1;
        for (int n = 0; n < 40; n++) begin
            int k = int'($urandom % 9);
            do_req(($urandom % 4 == 0) ? REV_OTHER : REV_A,
                   32'h2000_0000 + (($urandom % 4) << 28), offs[k],
                   bit'($urandom % 2), $urandom, "R12");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule